// File: doc/BRIEF.md
# Pipeline Hazard and Exception Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) around the three events that plain pipelining cannot absorb. The first is a load whose result is needed by the very next instruction. The second is a branch that is resolved as taken while it sits in decode. The third is an arithmetic overflow raised by the instruction in execute. Each cycle it looks at the register numbers the decoding instruction reads and at the destination and memory-read flag of the instruction in execute. It also takes the taken-branch flag from decode and the overflow flag, with that instruction's PC, from execute. From these it drives the write enables and flush and clear strobes of the PC and the pipeline registers, and it selects the PC source.

All steering outputs are combinational, so they act on the clock edge that closes the cycle in which the event is seen. A single priority order settles conflicts. An overflow beats everything else, because it flushes the three youngest instructions, and servicing the oldest instruction's fault first keeps program order. A load-use stall comes next. A taken branch comes last, because a branch stalled in decode has not yet used its true operands. The faulting PC is copied into an exception-PC register and a fixed code is written into a cause register; both are zero after reset.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the execute-stage instruction reads memory and its destination equals an in-use, non-zero source register of the decode instruction (either source), in the same cycle pc_we=0, ifid_we=0, idex_ctl_clr=1, ifid_flush=0, exmem_ctl_clr=0 and pc_sel=0 (sequential).
- R2: A matching destination whose memory-read flag is low (an ALU producer) causes no stall: pc_we=1, ifid_we=1, idex_ctl_clr=0.
- R3: Register 0 never matches. A source whose in-use flag is low never matches.
- R4: A taken branch with no stall and no overflow gives ifid_flush=1, pc_we=1, ifid_we=1, pc_sel=1 (branch target), idex_ctl_clr=0 and exmem_ctl_clr=0.
- R5: An overflow gives ifid_flush=1, idex_ctl_clr=1, exmem_ctl_clr=1, pc_we=1 and pc_sel=2 (exception vector, address 0x40000040).
- R6: Overflow takes priority over a stall and over a branch. A stall takes priority over a branch, so no flush is raised and pc_sel stays 0.
- R7: On the clock edge that ends an overflow cycle, epc loads ex_pc and cause loads 12 (the overflow code).
- R8: epc and cause are zero after reset and keep their values across every cycle without an overflow.
- R9: With no event, pc_we=1, ifid_we=1, all flush and clear strobes are 0, and pc_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_a | input | 5 | First source register of the decode instruction |
| id_src_a_used | input | 1 | First source is read by the decode instruction |
| id_src_b | input | 5 | Second source register of the decode instruction |
| id_src_b_used | input | 1 | Second source is read by the decode instruction |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| id_branch_taken | input | 1 | Branch in decode resolved as taken |
| ex_overflow | input | 1 | Arithmetic overflow in execute |
| ex_pc | input | 32 | PC of the instruction in execute |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_flush | output | 1 | Zero the fetch/decode register |
| idex_ctl_clr | output | 1 | Zero control fields entering decode/execute register |
| exmem_ctl_clr | output | 1 | Zero control fields entering execute/memory register |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 branch target, 2 exception vector |
| epc | output | 32 | Saved PC of the faulting instruction |
| cause | output | 32 | Cause code of the last exception |

## Verification
The steering outputs are due in the same cycle as their stimulus. The bench therefore drives each vector just after a falling edge and compares the strobes one time unit later, before the next rising edge. The epc and cause registers are due one rising edge after an overflow cycle, so the bench compares them just after that edge, against a value it tracks itself. The same post-edge check confirms they hold through cycles with no overflow.

// File: rtl/hzd_pkg.sv
// Shared types for the hazard and exception controller.
// Assumes a 2-bit PC-source select decoded by the fetch-stage multiplexer.
package hzd_pkg;
    typedef enum logic [1:0] {
        PCS_SEQ    = 2'd0,
        PCS_BRANCH = 2'd1,
        PCS_VECTOR = 2'd2
    } pc_src_e;

    typedef struct packed {
        logic    pc_we;
        logic    ifid_we;
        logic    ifid_flush;
        logic    idex_clr;
        logic    exmem_clr;
        pc_src_e pc_sel;
    } steer_t;
endpackage

// File: rtl/hzd_load_use.sv
// Load-use detector: flags a stall when the load in execute writes a register
// that the decode instruction reads. Assumes register 0 is hard-wired to zero
// and that the in-use flags come from the decoder.
module hzd_load_use #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] src,
    input  logic [NUM_SRC-1:0]             src_used,
    input  logic [REG_AW-1:0]              ex_dst,
    input  logic                           ex_mem_read,
    output logic                           stall
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Per-source match, excluding the zero register and unused sources.
        assign hit[i] = src_used[i] && (src[i] != '0) && (src[i] == ex_dst);
    end

    // A stall is needed only when the producer is a load.
    assign stall = ex_mem_read && (|hit);
endmodule

// File: rtl/hzd_arbiter.sv
// Priority arbiter: turns the exception, stall and branch events into pipeline
// steering. Order is exception, then stall, then branch.
module hzd_arbiter
    import hzd_pkg::*;
(
    input  logic   exc,
    input  logic   stall,
    input  logic   br_taken,
    output steer_t st
);
    // Combinational priority decode of the steering word.
    always_comb begin
        st.pc_we      = 1'b1;
        st.ifid_we    = 1'b1;
        st.ifid_flush = 1'b0;
        st.idex_clr   = 1'b0;
        st.exmem_clr  = 1'b0;
        st.pc_sel     = PCS_SEQ;
        if (exc) begin
            st.ifid_flush = 1'b1;
            st.idex_clr   = 1'b1;
            st.exmem_clr  = 1'b1;
            st.pc_sel     = PCS_VECTOR;
        end else if (stall) begin
            st.pc_we    = 1'b0;
            st.ifid_we  = 1'b0;
            st.idex_clr = 1'b1;
        end else if (br_taken) begin
            st.ifid_flush = 1'b1;
            st.pc_sel     = PCS_BRANCH;
        end
    end
endmodule

// File: rtl/hzd_exc_regs.sv
// Exception state: holds the faulting PC and the cause code. Both registers
// load only on a taken exception. Assumes one exception source per cycle.
module hzd_exc_regs #(
    parameter int          XLEN     = 32,
    parameter int          CAUSE_W  = 32,
    parameter logic [31:0] OVF_CODE = 32'd12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [XLEN-1:0]    fault_pc,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    // Capture the PC and the code on a taken exception; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (take) begin
            epc   <= fault_pc;
            cause <= CAUSE_W'(OVF_CODE);
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Top of the hazard and exception controller for a five-stage pipeline.
// Steering outputs are combinational; epc and cause are registered.
// Assumes forwarding elsewhere covers every non-load producer.
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int          REG_AW   = 5,
    parameter int          XLEN     = 32,
    parameter int          CAUSE_W  = 32,
    parameter logic [31:0] OVF_CODE = 32'd12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  id_src_a,
    input  logic               id_src_a_used,
    input  logic [REG_AW-1:0]  id_src_b,
    input  logic               id_src_b_used,
    input  logic [REG_AW-1:0]  ex_dst,
    input  logic               ex_mem_read,
    input  logic               id_branch_taken,
    input  logic               ex_overflow,
    input  logic [XLEN-1:0]    ex_pc,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ifid_flush,
    output logic               idex_ctl_clr,
    output logic               exmem_ctl_clr,
    output logic [1:0]         pc_sel,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] srcs;
    logic [NSRC-1:0]             srcs_used;
    logic                        stall;
    steer_t                      st;

    assign srcs      = {id_src_b, id_src_a};
    assign srcs_used = {id_src_b_used, id_src_a_used};

    hzd_load_use #(.REG_AW(REG_AW), .NUM_SRC(NSRC)) u_lu (
        .src         (srcs),
        .src_used    (srcs_used),
        .ex_dst      (ex_dst),
        .ex_mem_read (ex_mem_read),
        .stall       (stall)
    );

    hzd_arbiter u_arb (
        .exc      (ex_overflow),
        .stall    (stall),
        .br_taken (id_branch_taken),
        .st       (st)
    );

    hzd_exc_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .OVF_CODE(OVF_CODE)) u_exc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (ex_overflow),
        .fault_pc (ex_pc),
        .epc      (epc),
        .cause    (cause)
    );

    assign pc_we         = st.pc_we;
    assign ifid_we       = st.ifid_we;
    assign ifid_flush    = st.ifid_flush;
    assign idex_ctl_clr  = st.idex_clr;
    assign exmem_ctl_clr = st.exmem_clr;
    assign pc_sel        = st.pc_sel;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
// Checker for pipe_hazard_ctrl. It relates the steering outputs to each other
// and the exception registers to their inputs over time.
module pipe_hazard_ctrl_chk #(
    parameter int          XLEN     = 32,
    parameter int          CAUSE_W  = 32,
    parameter logic [31:0] OVF_CODE = 32'd12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ex_overflow,
    input logic [XLEN-1:0]    ex_pc,
    input logic               pc_we,
    input logic               ifid_we,
    input logic               ifid_flush,
    input logic               idex_ctl_clr,
    input logic               exmem_ctl_clr,
    input logic [1:0]         pc_sel,
    input logic [XLEN-1:0]    epc,
    input logic [CAUSE_W-1:0] cause
);
    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_ctl_clr && !exmem_ctl_clr) |-> (!pc_we && !ifid_we && !ifid_flush && pc_sel == 2'd0));
    // R5
    exc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_overflow |-> (ifid_flush && idex_ctl_clr && exmem_ctl_clr && pc_we && pc_sel == 2'd2));
    // R4
    flush_moves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (pc_we && ifid_we && pc_sel != 2'd0));
    // R6
    hold_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |-> (!ifid_flush && !exmem_ctl_clr));
    // R7
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_overflow |=> (epc == $past(ex_pc) && cause == CAUSE_W'(OVF_CODE)));
    // R8
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_overflow |=> ($stable(epc) && $stable(cause)));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .OVF_CODE(OVF_CODE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ex_overflow   (ex_overflow),
    .ex_pc         (ex_pc),
    .pc_we         (pc_we),
    .ifid_we       (ifid_we),
    .ifid_flush    (ifid_flush),
    .idex_ctl_clr  (idex_ctl_clr),
    .exmem_ctl_clr (exmem_ctl_clr),
    .pc_sel        (pc_sel),
    .epc           (epc),
    .cause         (cause)
);

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    // Vector: {src_a, a_used, src_b, b_used, ex_dst, mem_rd, br, ovf,
    //          exp pc_we, ifid_we, flush, idex_clr, exmem_clr, pc_sel[1:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {5'd1, 1'b1, 5'd3, 1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 5'b11000, 2'd0}, // R9 idle
        {5'd5, 1'b1, 5'd3, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 5'b00010, 2'd0}, // R1 src a
        {5'd2, 1'b1, 5'd9, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 5'b00010, 2'd0}, // R1 src b
        {5'd5, 1'b1, 5'd3, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 5'b11000, 2'd0}, // R2 alu producer
        {5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 5'b11000, 2'd0}, // R3 reg zero
        {5'd6, 1'b0, 5'd3, 1'b1, 5'd6, 1'b1, 1'b0, 1'b0, 5'b11000, 2'd0}, // R3 a unused
        {5'd4, 1'b1, 5'd8, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0, 5'b11000, 2'd0}, // R3 b unused
        {5'd1, 1'b1, 5'd2, 1'b1, 5'd7, 1'b0, 1'b1, 1'b0, 5'b11100, 2'd1}, // R4 branch
        {5'd4, 1'b1, 5'd2, 1'b1, 5'd4, 1'b1, 1'b1, 1'b0, 5'b00010, 2'd0}, // R6 stall > br
        {5'd1, 1'b1, 5'd2, 1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 5'b11111, 2'd2}, // R5 overflow
        {5'd4, 1'b1, 5'd2, 1'b1, 5'd4, 1'b1, 1'b0, 1'b1, 5'b11111, 2'd2}, // R6 ovf > stall
        {5'd1, 1'b1, 5'd2, 1'b1, 5'd7, 1'b0, 1'b1, 1'b1, 5'b11111, 2'd2}, // R6 ovf > br
        {5'd3, 1'b1, 5'd3, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 5'b00010, 2'd0}  // R1 both match
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  id_src_a = '0, id_src_b = '0, ex_dst = '0;
    logic        id_src_a_used = 1'b0, id_src_b_used = 1'b0;
    logic        ex_mem_read = 1'b0, id_branch_taken = 1'b0, ex_overflow = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        pc_we, ifid_we, ifid_flush, idex_ctl_clr, exmem_ctl_clr;
    logic [1:0]  pc_sel;
    logic [31:0] epc, cause;

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] exp_epc = '0;
    logic [31:0] exp_cause = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .id_src_a(id_src_a), .id_src_a_used(id_src_a_used),
        .id_src_b(id_src_b), .id_src_b_used(id_src_b_used),
        .ex_dst(ex_dst), .ex_mem_read(ex_mem_read),
        .id_branch_taken(id_branch_taken), .ex_overflow(ex_overflow), .ex_pc(ex_pc),
        .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
        .idex_ctl_clr(idex_ctl_clr), .exmem_ctl_clr(exmem_ctl_clr),
        .pc_sel(pc_sel), .epc(epc), .cause(cause)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, {32'd0, epc}, {32'd0, exp_epc});
        check(req, {32'd0, cause}, {32'd0, exp_cause});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 check_regs("R8 reset");
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {id_src_a, id_src_a_used, id_src_b, id_src_b_used,
             ex_dst, ex_mem_read, id_branch_taken, ex_overflow} = VEC[i][26:7];
            ex_pc = 32'h0000_1000 + 32'(i * 4);
            #1;
            check($sformatf("R1-table row %0d steering", i),
                  {57'd0, pc_we, ifid_we, ifid_flush, idex_ctl_clr, exmem_ctl_clr, pc_sel},
                  {57'd0, VEC[i][6:0]});
            if (ex_overflow) begin
                exp_epc   = ex_pc;
                exp_cause = 32'd12;
            end
            @(posedge clk);
            #1 check_regs(ex_overflow ? "R7 capture" : "R8 hold");
        end

        // R8: a reset after a capture returns epc and cause to zero.
        @(negedge clk);
        ex_overflow = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        exp_epc = '0;
        exp_cause = '0;
        #1 check_regs("R8 reset clears");
        @(negedge clk) rst_n = 1'b1;

        // R7: back-to-back overflows, the later one wins.
        @(negedge clk);
        ex_overflow = 1'b1;
        ex_pc = 32'hDEAD_0004;
        @(posedge clk);
        #1;
        exp_epc = 32'hDEAD_0004;
        exp_cause = 32'd12;
        check_regs("R7 first");
        @(negedge clk) ex_pc = 32'hBEEF_0008;
        @(posedge clk);
        #1;
        exp_epc = 32'hBEEF_0008;
        check_regs("R7 second");

        // R8: the registers hold over several quiet cycles.
        @(negedge clk);
        ex_overflow = 1'b0;
        ex_pc = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1 check_regs("R8 quiet hold");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule